// File: doc/BRIEF.md
# Receive Frame Event Status Register

This block turns the end-of-frame results of a receive MAC into a single 16-bit status word and holds it for the host. It counts the bytes of the frame as they arrive. When the frame ends it samples the CRC result, the number of trailing dribble bits, the destination-address comparator results, a 6-bit hash index and the accept-enable controls. From these it sorts the frame into good, runt, over-length or CRC-damaged, builds the status word, and may raise an interrupt request.

The word is always visible on `evt_word`. A host read strobe either clears the word (clearing view) or leaves it as it is (status view). When a frame is both good and accepted by the hash filter, the six upper bits carry the hash index instead of the individual flags. The one exception is a broadcast frame, which keeps the flag layout so that its broadcast flag survives. The length of the most recent good frame is kept in a separate register.

Top module: `rx_evt_status`

## Requirements
- R1: After reset `evt_word` is 0x0004, `irq` is low and `good_len` is 0. Bits 5..0 of `evt_word` read 6'b000100 at all times.
- R2: Bit 8 (good frame) is set only when the frame has no CRC error and its byte count lies between MIN_LEN and MAX_LEN inclusive.
- R3: Bit 12 flags a bad CRC. Bit 13 flags a count below MIN_LEN. Bit 14 flags a count above MAX_LEN. The byte counter stops at MAX_LEN+1, so bytes beyond that point are dropped without overflow.
- R4: Bit 7 is set when `drib_bits` (the count of bits after the last whole byte, 0..7) is nonzero. Bits 7 and 12 together denote an alignment error.
- R5: Bit 9 mirrors the hash-filter hit. When the frame is good, hash-hit and not a broadcast, bits 15..10 equal `hash_idx`. Otherwise bits 15..10 hold the flag layout, with bit 15 at 0.
- R6: Bit 6 is set only when the frame is good, hash-hit and `acc_hash_en` is 1.
- R7: In flag layout, bit 10 is set for a good frame with `ia_hit` and `acc_ia_en`. Bit 11 is set for a good frame with `bc_hit` and `acc_bc_en`.
- R8: A read with `rd_stb`=1 and `rd_clr_view`=1 returns `evt_word` to 0x0004 on the next edge. A read with `rd_clr_view`=0 leaves it unchanged.
- R9: If `rx_end` coincides with a clearing read, the new frame's word is stored and is not cleared.
- R10: `irq` rises after a frame whose good, CRC, runt or over-length event has its own enable set. It then stays high until a clearing read without a new interrupting frame in the same cycle.
- R11: `good_len` takes the byte count of each good frame. Frames that are not good leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 1 | One received byte this cycle |
| rx_end | input | 1 | Frame complete; result inputs valid |
| crc_bad | input | 1 | CRC check failed |
| drib_bits | input | 3 | Bits after last whole byte |
| ia_hit | input | 1 | Destination matched individual address |
| bc_hit | input | 1 | Destination is all ones |
| hash_hit | input | 1 | Hash filter accepted destination |
| hash_idx | input | 6 | Hash table index |
| acc_ia_en | input | 1 | Individual-address accept enable |
| acc_bc_en | input | 1 | Broadcast accept enable |
| acc_hash_en | input | 1 | Hash accept enable |
| ie_good | input | 1 | Interrupt enable, good frame |
| ie_crc | input | 1 | Interrupt enable, CRC error |
| ie_runt | input | 1 | Interrupt enable, runt |
| ie_long | input | 1 | Interrupt enable, over-length |
| rd_stb | input | 1 | Host read strobe |
| rd_clr_view | input | 1 | 1 = clearing view, 0 = status view |
| evt_word | output | 16 | Status word |
| irq | output | 1 | Interrupt request |
| good_len | output | CW | Byte count of last good frame |

## Verification
The bench builds the block with MIN_LEN=8 and MAX_LEN=20, so that runts, frames exactly at both limits, and frames well past saturation each take only a few dozen cycles. At these settings a single run can cover counter saturation and the drop of extra bytes, the edges just inside and just outside the length window, and the overlap of a clearing read with a frame end. The hash and broadcast layout cases are exercised at the same time.

// File: rtl/rxev_pkg.sv
package rxev_pkg;
    localparam int WORD_W = 16;
    localparam int IDX_W  = 6;
    localparam logic [5:0] ID_CODE = 6'b000100;
    localparam logic [WORD_W-1:0] RST_WORD = 16'h0004;

    localparam int B_HASHEV = 6;
    localparam int B_DRIB   = 7;
    localparam int B_GOOD   = 8;
    localparam int B_HASHED = 9;
    localparam int B_IA     = 10;
    localparam int B_BC     = 11;
    localparam int B_CRC    = 12;
    localparam int B_RUNT   = 13;
    localparam int B_LONG   = 14;

    typedef struct packed {
        logic             crc_bad;
        logic [2:0]       drib_bits;
        logic             ia_hit;
        logic             bc_hit;
        logic             hash_hit;
        logic [IDX_W-1:0] hash_idx;
    } frm_info_t;

    typedef struct packed {
        logic acc_ia;
        logic acc_bc;
        logic acc_hash;
        logic ie_good;
        logic ie_crc;
        logic ie_runt;
        logic ie_long;
    } rx_cfg_t;
endpackage

// File: rtl/rxev_len_cnt.sv
module rxev_len_cnt #(
    parameter int MAX_LEN = 1518,
    parameter int CW      = $clog2(MAX_LEN + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_vld,
    input  logic          frm_end,
    output logic [CW-1:0] frm_len
);
    localparam logic [CW-1:0] SAT = CW'(MAX_LEN + 1);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] len_now;

    always_comb begin
        len_now = cnt_q;
        if (byte_vld && (cnt_q != SAT)) begin
            len_now = cnt_q + ONE;
        end
        cnt_d   = frm_end ? '0 : len_now;
        frm_len = len_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R3: the counter never passes its saturation point
    a_r3_cnt_sat: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SAT);

    // R3: while saturated, further bytes leave the count where it is
    a_r3_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == SAT && !frm_end) |=> (cnt_q == SAT));
endmodule

// File: rtl/rxev_classify.sv
module rxev_classify
    import rxev_pkg::*;
#(
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518,
    parameter int CW      = $clog2(MAX_LEN + 2)
) (
    input  logic [CW-1:0]     frm_len,
    input  frm_info_t         info,
    input  rx_cfg_t           cfg,
    output logic [WORD_W-1:0] word,
    output logic              good,
    output logic              irq_req
);
    localparam logic [CW-1:0] LO = CW'(MIN_LEN);
    localparam logic [CW-1:0] HI = CW'(MAX_LEN);

    logic runt, too_long, hash_lay;

    always_comb begin
        runt     = (frm_len < LO);
        too_long = (frm_len > HI);
        good     = !info.crc_bad && !runt && !too_long;
        hash_lay = good && info.hash_hit && !info.bc_hit;

        word           = '0;
        word[5:0]      = ID_CODE;
        word[B_HASHEV] = good && info.hash_hit && cfg.acc_hash;
        word[B_DRIB]   = (info.drib_bits != 3'd0);
        word[B_GOOD]   = good;
        word[B_HASHED] = info.hash_hit;
        if (hash_lay) begin
            word[15:10] = info.hash_idx;
        end else begin
            word[B_IA]   = good && info.ia_hit && cfg.acc_ia;
            word[B_BC]   = good && info.bc_hit && cfg.acc_bc;
            word[B_CRC]  = info.crc_bad;
            word[B_RUNT] = runt;
            word[B_LONG] = too_long;
        end

        irq_req = (good && cfg.ie_good) || (info.crc_bad && cfg.ie_crc) ||
                  (runt && cfg.ie_runt) || (too_long && cfg.ie_long);
    end
endmodule

// File: rtl/rx_evt_status.sv
module rx_evt_status
    import rxev_pkg::*;
#(
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518,
    parameter int CW      = $clog2(MAX_LEN + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_byte,
    input  logic          rx_end,
    input  logic          crc_bad,
    input  logic [2:0]    drib_bits,
    input  logic          ia_hit,
    input  logic          bc_hit,
    input  logic          hash_hit,
    input  logic [5:0]    hash_idx,
    input  logic          acc_ia_en,
    input  logic          acc_bc_en,
    input  logic          acc_hash_en,
    input  logic          ie_good,
    input  logic          ie_crc,
    input  logic          ie_runt,
    input  logic          ie_long,
    input  logic          rd_stb,
    input  logic          rd_clr_view,
    output logic [15:0]   evt_word,
    output logic          irq,
    output logic [CW-1:0] good_len
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              irq;
        logic [CW-1:0]     glen;
    } regs_t;

    regs_t         st_d, st_q;
    frm_info_t     info;
    rx_cfg_t       cfg;
    logic [CW-1:0] frm_len;
    logic [WORD_W-1:0] cls_word;
    logic          cls_good, cls_irq, clr_rd;

    assign info = '{crc_bad: crc_bad, drib_bits: drib_bits, ia_hit: ia_hit,
                    bc_hit: bc_hit, hash_hit: hash_hit, hash_idx: hash_idx};
    assign cfg  = '{acc_ia: acc_ia_en, acc_bc: acc_bc_en, acc_hash: acc_hash_en,
                    ie_good: ie_good, ie_crc: ie_crc, ie_runt: ie_runt,
                    ie_long: ie_long};

    rxev_len_cnt #(.MAX_LEN(MAX_LEN), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .byte_vld(rx_byte), .frm_end(rx_end),
        .frm_len(frm_len)
    );

    rxev_classify #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .CW(CW)) u_cls (
        .frm_len(frm_len), .info(info), .cfg(cfg),
        .word(cls_word), .good(cls_good), .irq_req(cls_irq)
    );

    always_comb begin
        clr_rd = rd_stb && rd_clr_view;
        st_d   = st_q;
        if (rx_end) begin
            st_d.word = cls_word;
            if (cls_good) begin
                st_d.glen = frm_len;
            end
        end else if (clr_rd) begin
            st_d.word = RST_WORD;
        end
        st_d.irq = (rx_end && cls_irq) || (st_q.irq && !clr_rd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{word: RST_WORD, irq: 1'b0, glen: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_word = st_q.word;
    assign irq      = st_q.irq;
    assign good_len = st_q.glen;

    // R1: identification code in the low bits
    a_r1_id_code: assert property (@(posedge clk) disable iff (!rst_n)
        evt_word[5:0] == 6'b000100);

    // R2: a good-frame word in flag layout shows no error flag
    a_r2_good_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_word[8] && !evt_word[9]) |-> (evt_word[14:12] == 3'b000));

    // R6: hash event requires good and hashed
    a_r6_hash_ev: assert property (@(posedge clk) disable iff (!rst_n)
        evt_word[6] |-> (evt_word[8] && evt_word[9]));

    // R8: a clearing read with no frame end restores the reset word
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_clr_view && !rx_end) |=> (evt_word == 16'h0004));

    // R8: with no frame end and no clearing read the word is held
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_end && !(rd_stb && rd_clr_view)) |=> $stable(evt_word));

    // R10: the request only rises at a frame end
    a_r10_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_end && !irq) |=> !irq);

    // R11: the length register only moves at a frame end
    a_r11_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_end |=> $stable(good_len));
endmodule

// File: tb/rx_evt_status_tb.sv
module rx_evt_status_tb;
    localparam int MIN_L = 8;
    localparam int MAX_L = 20;
    localparam int CW    = $clog2(MAX_L + 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_byte = 0, rx_end = 0, crc_bad = 0, ia_hit = 0, bc_hit = 0, hash_hit = 0;
    logic [2:0] drib_bits = 0;
    logic [5:0] hash_idx = 0;
    logic acc_ia_en = 0, acc_bc_en = 0, acc_hash_en = 0;
    logic ie_good = 0, ie_crc = 0, ie_runt = 0, ie_long = 0;
    logic rd_stb = 0, rd_clr_view = 0;
    logic [15:0] evt_word;
    logic irq;
    logic [CW-1:0] good_len;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    // reference model state
    int m_cnt = 0;
    logic [15:0] m_word = 16'h0004;
    bit m_irq = 0;
    int m_len = 0;

    always #5 clk = ~clk;

    rx_evt_status #(.MIN_LEN(MIN_L), .MAX_LEN(MAX_L), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_end(rx_end),
        .crc_bad(crc_bad), .drib_bits(drib_bits), .ia_hit(ia_hit),
        .bc_hit(bc_hit), .hash_hit(hash_hit), .hash_idx(hash_idx),
        .acc_ia_en(acc_ia_en), .acc_bc_en(acc_bc_en), .acc_hash_en(acc_hash_en),
        .ie_good(ie_good), .ie_crc(ie_crc), .ie_runt(ie_runt), .ie_long(ie_long),
        .rd_stb(rd_stb), .rd_clr_view(rd_clr_view),
        .evt_word(evt_word), .irq(irq), .good_len(good_len)
    );

    function automatic string tag_of(logic [15:0] d);
        if (d[5:0] != 0) return "R1";
        if (d[6]) return "R6";
        if (d[7]) return "R4";
        if (d[8]) return "R2";
        if (d[9] || d[15]) return "R5";
        if (d[10] || d[11]) return "R7";
        return "R3";
    endfunction

    function automatic logic [15:0] ref_word(int len);
        logic [15:0] w;
        bit ok, sh, lg;
        sh = (len < MIN_L);
        lg = (len > MAX_L);
        ok = !crc_bad && !sh && !lg;
        w = 16'h0004;
        if (drib_bits != 0) w[7] = 1;
        if (ok) w[8] = 1;
        if (hash_hit) w[9] = 1;
        if (ok && hash_hit && acc_hash_en) w[6] = 1;
        if (ok && hash_hit && !bc_hit) begin
            w[15:10] = hash_idx;
        end else begin
            if (ok && ia_hit && acc_ia_en) w[10] = 1;
            if (ok && bc_hit && acc_bc_en) w[11] = 1;
            if (crc_bad) w[12] = 1;
            if (sh) w[13] = 1;
            if (lg) w[14] = 1;
        end
        return w;
    endfunction

    // behavioural model, inputs are changed only at falling edges
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_word = 16'h0004; m_irq = 0; m_len = 0;
        end else begin
            int len;
            bit ok, fire, clr;
            len = m_cnt;
            if (rx_byte && len < MAX_L + 1) len = len + 1;
            clr = rd_stb && rd_clr_view;
            if (rx_end) begin
                m_word = ref_word(len);
                ok = m_word[8];
                fire = (ok && ie_good) || (crc_bad && ie_crc) ||
                       (len < MIN_L && ie_runt) || (len > MAX_L && ie_long);
                if (ok) m_len = len;
                m_irq = fire || (m_irq && !clr);
                m_cnt = 0;
            end else begin
                if (clr) m_word = 16'h0004;
                if (clr) m_irq = 0;
                m_cnt = len;
            end
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (evt_word !== m_word) begin
                errors++;
                $display("FAIL %s cycle %0d evt_word actual %h expected %h",
                         tag_of(evt_word ^ m_word), cyc, evt_word, m_word);
            end
            checks++;
            if (irq !== m_irq) begin
                errors++;
                $display("FAIL R10 cycle %0d irq actual %0b expected %0b", cyc, irq, m_irq);
            end
            checks++;
            if (good_len !== CW'(m_len)) begin
                errors++;
                $display("FAIL R11 cycle %0d good_len actual %0d expected %0d", cyc, good_len, m_len);
            end
        end
    end

    task automatic chk(string rq, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic frame(int n, bit crc, logic [2:0] drib, bit ia, bit bc, bit hh,
                         logic [5:0] idx, bit clr_at_end);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_byte = 1;
        end
        @(negedge clk);
        rx_byte = 0; rx_end = 1; crc_bad = crc; drib_bits = drib;
        ia_hit = ia; bc_hit = bc; hash_hit = hh; hash_idx = idx;
        rd_stb = clr_at_end; rd_clr_view = clr_at_end;
        @(negedge clk);
        rx_end = 0; crc_bad = 0; drib_bits = 0; ia_hit = 0; bc_hit = 0;
        hash_hit = 0; hash_idx = 0; rd_stb = 0; rd_clr_view = 0;
    endtask

    task automatic host_read(bit clr);
        @(negedge clk);
        rd_stb = 1; rd_clr_view = clr;
        @(negedge clk);
        rd_stb = 0; rd_clr_view = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", evt_word, 16'h0004);
        chk("R1", {15'd0, irq}, 16'h0000);
        chk("R11", 16'(good_len), 16'h0000);

        // R2 good frame, irq from good event (R10)
        ie_good = 1; ie_crc = 1; ie_runt = 1; ie_long = 1;
        frame(10, 0, 0, 0, 0, 0, 0, 0);
        chk("R2", evt_word, 16'h0104);
        chk("R10", {15'd0, irq}, 16'h0001);
        chk("R11", 16'(good_len), 16'd10);

        // R8 status view keeps, clearing view clears
        host_read(0);
        chk("R8", evt_word, 16'h0104);
        chk("R10", {15'd0, irq}, 16'h0001);
        host_read(1);
        chk("R8", evt_word, 16'h0004);
        chk("R10", {15'd0, irq}, 16'h0000);

        // R3 R4 CRC with dribble: alignment error
        frame(12, 1, 3'd5, 0, 0, 0, 0, 0);
        chk("R4", evt_word, 16'h1084);
        chk("R11", 16'(good_len), 16'd10);
        host_read(1);

        // R3 runt and over-length, saturation, boundaries
        frame(5, 0, 0, 0, 0, 0, 0, 0);
        chk("R3", evt_word, 16'h2004);
        frame(35, 0, 0, 0, 0, 0, 0, 0);
        chk("R3", evt_word, 16'h4004);
        chk("R11", 16'(good_len), 16'd10);
        frame(MIN_L, 0, 0, 0, 0, 0, 0, 0);
        chk("R2", evt_word, 16'h0104);
        chk("R11", 16'(good_len), 16'(MIN_L));
        frame(MAX_L, 0, 0, 0, 0, 0, 0, 0);
        chk("R2", evt_word, 16'h0104);
        chk("R11", 16'(good_len), 16'(MAX_L));
        frame(MAX_L + 1, 0, 0, 0, 0, 0, 0, 0);
        chk("R3", evt_word, 16'h4004);
        frame(MIN_L - 1, 0, 0, 0, 0, 0, 0, 0);
        chk("R3", evt_word, 16'h2004);
        host_read(1);

        // R5 R6 hash index layout
        acc_hash_en = 1;
        frame(15, 0, 0, 0, 0, 1, 6'h2A, 0);
        chk("R5", evt_word, 16'hAB44);
        // R5 R7 broadcast keeps flag layout
        acc_bc_en = 1;
        frame(15, 0, 0, 0, 1, 1, 6'h2A, 0);
        chk("R7", evt_word, 16'h0B44);
        // R6 hash enable off
        acc_hash_en = 0;
        frame(15, 0, 0, 0, 0, 1, 6'h15, 0);
        chk("R6", evt_word, 16'h5704);
        // R5 hashed on a bad frame keeps flags
        frame(15, 1, 0, 0, 0, 1, 6'h3F, 0);
        chk("R5", evt_word, 16'h1204);

        // R7 individual address on and off, broadcast enable off
        acc_ia_en = 1;
        frame(9, 0, 0, 1, 0, 0, 0, 0);
        chk("R7", evt_word, 16'h0504);
        acc_ia_en = 0; acc_bc_en = 0;
        frame(9, 0, 0, 1, 1, 0, 0, 0);
        chk("R7", evt_word, 16'h0104);
        host_read(1);

        // R9 frame end coincides with clearing read
        frame(11, 1, 0, 0, 0, 0, 0, 1);
        chk("R9", evt_word, 16'h1004);
        chk("R9", {15'd0, irq}, 16'h0001);
        host_read(1);

        // R10 disabled events leave irq low
        ie_crc = 0; ie_runt = 0;
        frame(11, 1, 0, 0, 0, 0, 0, 0);
        chk("R10", {15'd0, irq}, 16'h0000);
        frame(3, 0, 0, 0, 0, 0, 0, 0);
        chk("R10", {15'd0, irq}, 16'h0000);
        ie_long = 0;
        frame(25, 0, 0, 0, 0, 0, 0, 0);
        chk("R10", {15'd0, irq}, 16'h0000);
        ie_long = 1;
        frame(25, 0, 0, 0, 0, 0, 0, 0);
        chk("R10", {15'd0, irq}, 16'h0001);
        // R10 irq survives a status-view read
        host_read(0);
        chk("R10", {15'd0, irq}, 16'h0001);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule